// File: doc/BRIEF.md
# Four-Lane Vector Register Unit

This coprocessor block holds a small file of vector registers: four registers, each with four 64-bit lanes. A host sequencer issues one command at a time by raising `start` for a single cycle, with an opcode, a register selector and a second operand that is either a word address or a second register index. The unit then moves a whole register to or from a shared word-addressed memory port, or combines two registers lane by lane. When the command has finished, it raises `done` for exactly one cycle.

Memory transfers move one lane per cycle. Lane i always goes to or comes from address base+i. The memory returns read data one cycle after the cycle in which `memRd` is high. The four arithmetic lanes are computed in parallel in a single cycle. The register named by `regSel` is both the first operand and the destination.

Top module: `vlane_unit`

## Requirements
- R1: After reset, `done`, `memRd` and `memWr` are low and every lane of every register holds zero.
- R2: Opcode 14 (load) drives `memRd` for four consecutive cycles, starting the cycle after `start`, at addresses `operand`+0 to +3. Each word returned one cycle later is written into lane i of register `regSel`.
- R3: Opcode 15 (store) drives `memWr` for four consecutive cycles, starting the cycle after `start`. In the cycle with address `operand`+i, `memWdata` carries lane i of register `regSel`.
- R4: Opcode 16 replaces each lane of register `regSel` with its sum with the same lane of register `operand[1:0]`, modulo 2^64.
- R5: Opcode 17 replaces each lane of register `regSel` with that lane minus the same lane of register `operand[1:0]`, modulo 2^64.
- R6: Opcode 18 replaces each lane of register `regSel` with the low 64 bits of its unsigned product with the same lane of register `operand[1:0]`.
- R7: Opcode 19 replaces each lane of register `regSel` with the unsigned quotient by the same lane of register `operand[1:0]`. A lane whose divisor is zero becomes all ones, and the other lanes are unaffected.
- R8: When `regSel` equals `operand[1:0]`, each lane is combined with itself; subtraction, for example, yields zero.
- R9: `done` is high for exactly one cycle. It comes 2 cycles after `start` for arithmetic, 5 cycles after for a store and 6 cycles after for a load.
- R10: `memRd` and `memWr` are never high together, and both are low outside a transfer. A `start` that arrives while a command is in progress, or that carries any opcode other than 14 to 19, has no effect on registers, the port or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle command strobe |
| opcode | input | 5 | Command code (14 to 19) |
| regSel | input | 2 | Destination and first-operand register |
| operand | input | 16 | Base word address, or second register index in bits [1:0] |
| done | output | 1 | One-cycle completion pulse |
| memRd | output | 1 | Memory read request |
| memWr | output | 1 | Memory write request |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, valid one cycle after `memRd` |

## Verification
During a load, the cycle that issues the read for lane i+1 is also the cycle that writes the returned word for lane i. The bench provokes this overlap by loading all four registers from distinct patterns and storing them back. Any skew between lane and address would show up as a misplaced word. The other collision is a new `start` landing in a busy window: the bench pulses an add during a store, then confirms the store's timing, the absence of a second `done` and the unchanged register contents.

// File: rtl/vlu_pkg.sv
`timescale 1ns/1ps
package vlu_pkg;

  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OP_VLOAD  = 5'd14;
  localparam logic [OPC_W-1:0] OP_VSTORE = 5'd15;
  localparam logic [OPC_W-1:0] OP_VADD   = 5'd16;
  localparam logic [OPC_W-1:0] OP_VSUB   = 5'd17;
  localparam logic [OPC_W-1:0] OP_VMUL   = 5'd18;
  localparam logic [OPC_W-1:0] OP_VDIV   = 5'd19;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_MUL,
    ALU_DIV
  } alu_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_LDRAIN,
    S_STORE,
    S_EXEC,
    S_FIN
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic ldWrite;
    logic execArith;
    alu_e aluSel;
  } vlu_strobe_t;

endpackage

// File: rtl/vlu_lane_alu.sv
`timescale 1ns/1ps
module vlu_lane_alu
  import vlu_pkg::*;
#(
  parameter int ELEM_W = 64
) (
  input  logic [ELEM_W-1:0] a,
  input  logic [ELEM_W-1:0] b,
  input  alu_e              sel,
  output logic [ELEM_W-1:0] y
);

  always_comb begin
    unique case (sel)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_MUL: y = a * b;
      ALU_DIV: y = (b == '0) ? '1 : a / b;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/vlu_ctrl.sv
`timescale 1ns/1ps
module vlu_ctrl
  import vlu_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NREG   = 4,
  parameter int ADDR_W = 16,
  localparam int LANE_W = $clog2(LANES),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [REG_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] operand,
  output vlu_strobe_t       strobe,
  output logic [REG_W-1:0]  dstIdx,
  output logic [REG_W-1:0]  srcIdx,
  output logic [LANE_W-1:0] rdLane,
  output logic [LANE_W-1:0] wrLane,
  output logic              done,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr
);

  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  state_e            state;
  logic [LANE_W-1:0] cnt;
  logic [ADDR_W-1:0] base;
  alu_e              aluSel;
  logic              pendValid;
  logic [LANE_W-1:0] pendLane;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cnt       <= '0;
      base      <= '0;
      dstIdx    <= '0;
      srcIdx    <= '0;
      aluSel    <= ALU_ADD;
      pendValid <= 1'b0;
      pendLane  <= '0;
    end else begin
      // a read issued this cycle returns its word next cycle
      pendValid <= (state == S_LOAD);
      pendLane  <= cnt;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            cnt    <= '0;
            dstIdx <= regSel;
            srcIdx <= operand[REG_W-1:0];
            base   <= operand;
            case (opcode)
              OP_VLOAD:  state <= S_LOAD;
              OP_VSTORE: state <= S_STORE;
              OP_VADD: begin aluSel <= ALU_ADD; state <= S_EXEC; end
              OP_VSUB: begin aluSel <= ALU_SUB; state <= S_EXEC; end
              OP_VMUL: begin aluSel <= ALU_MUL; state <= S_EXEC; end
              OP_VDIV: begin aluSel <= ALU_DIV; state <= S_EXEC; end
              default: state <= S_IDLE;
            endcase
          end
        end
        S_LOAD: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_LANE) state <= S_LDRAIN;
        end
        S_STORE: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_LANE) state <= S_FIN;
        end
        S_LDRAIN: state <= S_FIN;
        S_EXEC:   state <= S_FIN;
        S_FIN:    state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.ldWrite   = pendValid;
    strobe.execArith = (state == S_EXEC);
    strobe.aluSel    = aluSel;
  end

  assign rdLane  = cnt;
  assign wrLane  = pendLane;
  assign memRd   = (state == S_LOAD);
  assign memWr   = (state == S_STORE);
  assign done    = (state == S_FIN);
  assign memAddr = base + ADDR_W'(cnt);

endmodule

// File: rtl/vlu_dpath.sv
`timescale 1ns/1ps
module vlu_dpath
  import vlu_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NREG   = 4,
  parameter int ELEM_W = 64,
  localparam int LANE_W = $clog2(LANES),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vlu_strobe_t       strobe,
  input  logic [REG_W-1:0]  dstIdx,
  input  logic [REG_W-1:0]  srcIdx,
  input  logic [LANE_W-1:0] rdLane,
  input  logic [LANE_W-1:0] wrLane,
  input  logic [ELEM_W-1:0] memRdata,
  output logic [ELEM_W-1:0] memWdata
);

  logic [ELEM_W-1:0] vreg    [NREG][LANES];
  logic [ELEM_W-1:0] laneRes [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vlu_lane_alu #(.ELEM_W(ELEM_W)) u_alu (
      .a   (vreg[dstIdx][l]),
      .b   (vreg[srcIdx][l]),
      .sel (strobe.aluSel),
      .y   (laneRes[l])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NREG; r++) begin
        for (int l = 0; l < LANES; l++) begin
          vreg[r][l] <= '0;
        end
      end
    end else if (strobe.ldWrite) begin
      vreg[dstIdx][wrLane] <= memRdata;
    end else if (strobe.execArith) begin
      for (int l = 0; l < LANES; l++) begin
        vreg[dstIdx][l] <= laneRes[l];
      end
    end
  end

  assign memWdata = vreg[dstIdx][rdLane];

endmodule

// File: rtl/vlane_unit.sv
`timescale 1ns/1ps
module vlane_unit
  import vlu_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int NREG   = 4,
  parameter int ELEM_W = 64,
  parameter int ADDR_W = 16,
  localparam int LANE_W = $clog2(LANES),
  localparam int REG_W  = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [REG_W-1:0]  regSel,
  input  logic [ADDR_W-1:0] operand,
  output logic              done,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ELEM_W-1:0] memWdata,
  input  logic [ELEM_W-1:0] memRdata
);

  vlu_strobe_t       strobe;
  logic [REG_W-1:0]  dstIdx;
  logic [REG_W-1:0]  srcIdx;
  logic [LANE_W-1:0] rdLane;
  logic [LANE_W-1:0] wrLane;

  vlu_ctrl #(.LANES(LANES), .NREG(NREG), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opcode  (opcode),
    .regSel  (regSel),
    .operand (operand),
    .strobe  (strobe),
    .dstIdx  (dstIdx),
    .srcIdx  (srcIdx),
    .rdLane  (rdLane),
    .wrLane  (wrLane),
    .done    (done),
    .memRd   (memRd),
    .memWr   (memWr),
    .memAddr (memAddr)
  );

  vlu_dpath #(.LANES(LANES), .NREG(NREG), .ELEM_W(ELEM_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dstIdx   (dstIdx),
    .srcIdx   (srcIdx),
    .rdLane   (rdLane),
    .wrLane   (wrLane),
    .memRdata (memRdata),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/vlane_unit_chk.sv
`timescale 1ns/1ps
module vlane_unit_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              memRd,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr
);

  p_port_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memRd && !memWr));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_rd_consecutive_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memRd && $past(memRd)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  p_wr_consecutive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memWr && $past(memWr)) |-> (memAddr == $past(memAddr) + ADDR_W'(1)));

  p_store_then_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWr) |-> done);

  p_load_then_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRd) |=> done);

endmodule

bind vlane_unit vlane_unit_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .memRd   (memRd),
  .memWr   (memWr),
  .memAddr (memAddr)
);

// File: tb/test_vlane_unit.sv
`timescale 1ns/1ps
module test_vlane_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  opcode = '0;
  logic [1:0]  regSel = '0;
  logic [15:0] operand = '0;
  logic        done;
  logic        memRd;
  logic        memWr;
  logic [15:0] memAddr;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;

  logic [63:0] mem   [0:63];
  logic [63:0] model [0:3][0:3];

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vlane_unit i_vlane_unit (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .regSel(regSel),
    .operand(operand), .done(done), .memRd(memRd), .memWr(memWr),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // memory with one cycle of read latency
  always @(posedge clk) begin
    if (memWr) mem[memAddr[5:0]] <= memWdata;
    if (memRd) memRdata <= mem[memAddr[5:0]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int r, input int l, input int s);
    if (((r + l + s) % 5) == 0) return 64'd0;
    if (((r + l + s) % 3) == 1) return 64'(r * 31 + l * 7 + s + 1);
    return 64'hFEDC_BA98_7654_3210 ^ (64'(r * 4 + l + s + 1) * 64'h0123_4567_89AB_CDEF);
  endfunction

  function automatic logic [63:0] calc(input int op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      16: return a + b;
      17: return a - b;
      18: return a * b;
      default: return (b == 64'd0) ? {64{1'b1}} : a / b;
    endcase
  endfunction

  // issue a command and judge its latency, port traffic and done width (R9, R2, R3, R10)
  task automatic runOp(input int op, input int a, input int b, input int expLat,
                       input int expRd, input int expWr, input string tag);
    int cyc = 1;
    int rdN = 0;
    int wrN = 0;
    bit seqOk = 1;
    logic [15:0] firstA = '0;
    logic [15:0] lastA = '0;
    @(negedge clk);
    start = 1'b1; opcode = 5'(op); regSel = 2'(a); operand = 16'(b);
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 40) begin
      if (memRd || memWr) begin
        if (rdN + wrN == 0) firstA = memAddr;
        else if (memAddr != lastA + 16'd1) seqOk = 0;
        lastA = memAddr;
        if (memRd && memWr) seqOk = 0;
      end
      rdN += int'(memRd);
      wrN += int'(memWr);
      @(negedge clk);
      cyc++;
    end
    check(cyc == expLat, "R9", {tag, " done latency"}, 64'(cyc), 64'(expLat));
    check(rdN == expRd && wrN == expWr, "R10", {tag, " port beats rd*16+wr"},
          64'(rdN * 16 + wrN), 64'(expRd * 16 + expWr));
    if (expRd + expWr > 0)
      check(seqOk && firstA == 16'(b), (expRd > 0) ? "R2" : "R3",
            {tag, " first address"}, 64'(firstA), 64'(b));
    @(negedge clk);
    check(!done, "R9", {tag, " done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic storeCompare(input int r, input int base, input string tag, input string what);
    runOp(15, r, base, 5, 0, 4, tag);
    for (int l = 0; l < 4; l++)
      check(mem[base + l] === model[r][l], tag, what, mem[base + l], model[r][l]);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int r = 0; r < 4; r++) for (int l = 0; l < 4; l++) model[r][l] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: quiet port after reset, registers cleared
    check(!done && !memRd && !memWr, "R1", "outputs after reset",
          {61'd0, done, memRd, memWr}, 64'd0);
    for (int i = 48; i < 64; i++) mem[i] = 64'hDEAD;
    for (int r = 0; r < 4; r++) storeCompare(r, 48 + r * 4, "R1", "reset lane value");

    // R2: explicit load of distinct words, read back through a store
    for (int l = 0; l < 4; l++) mem[20 + l] = 64'hA5A5_0000_0000_0000 + 64'(l * 3 + 1);
    runOp(14, 2, 20, 6, 4, 0, "R2");
    for (int l = 0; l < 4; l++) model[2][l] = mem[20 + l];
    storeCompare(2, 44, "R2", "loaded lane");

    // R4..R8: every opcode against every register pair
    for (int op = 16; op <= 19; op++) begin
      for (int d = 0; d < 4; d++) begin
        for (int s = 0; s < 4; s++) begin
          int seed = op * 16 + d * 4 + s;
          string tag;
          logic [63:0] res [0:3];
          case (op)
            16: tag = (d == s) ? "R8/R4" : "R4";
            17: tag = (d == s) ? "R8/R5" : "R5";
            18: tag = (d == s) ? "R8/R6" : "R6";
            default: tag = (d == s) ? "R8/R7" : "R7";
          endcase
          for (int r = 0; r < 4; r++)
            for (int l = 0; l < 4; l++) mem[r * 4 + l] = pat(r, l, seed);
          for (int r = 0; r < 4; r++) begin
            runOp(14, r, r * 4, 6, 4, 0, "R2");
            for (int l = 0; l < 4; l++) model[r][l] = pat(r, l, seed);
          end
          for (int l = 0; l < 4; l++) res[l] = calc(op, model[d][l], model[s][l]);
          runOp(op, d, s, 2, 0, 0, tag);
          for (int l = 0; l < 4; l++) model[d][l] = res[l];
          storeCompare(d, 40, tag, "lane result");
          if (d != s) storeCompare(s, 32, tag, "source kept");
        end
      end
    end

    // R10: start while a store is busy is ignored
    begin
      int cyc;
      @(negedge clk);
      start = 1'b1; opcode = 5'd15; regSel = 2'd1; operand = 16'd48;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; opcode = 5'd16; regSel = 2'd1; operand = 16'd1;
      @(negedge clk);
      start = 1'b0;
      cyc = 3;
      while (!done && cyc < 40) begin @(negedge clk); cyc++; end
      check(cyc == 5, "R10", "busy store latency", 64'(cyc), 64'd5);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        check(!done && !memRd && !memWr, "R10", "no action from busy start",
              {61'd0, done, memRd, memWr}, 64'd0);
      end
      for (int l = 0; l < 4; l++)
        check(mem[48 + l] === model[1][l], "R10", "store during busy", mem[48 + l], model[1][l]);
      storeCompare(1, 52, "R10", "register untouched");
    end

    // R10: unsupported opcode is ignored
    @(negedge clk);
    start = 1'b1; opcode = 5'd3; regSel = 2'd0; operand = 16'd0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(!done && !memRd && !memWr, "R10", "unknown opcode quiet",
            {61'd0, done, memRd, memWr}, 64'd0);
      @(negedge clk);
    end
    storeCompare(0, 56, "R10", "register after unknown opcode");

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule